// File: doc/BRIEF.md
# Write-Once Memory Clock Divider

This block derives the slow timing reference that a nonvolatile-memory controller needs for its erase and program pulses. It sits on the bus clock and takes an 8-bit configuration byte through a small register port: a divisor field and a select that inserts a divide-by-8 stage ahead of the divider. The output is a one-bus-cycle tick enable at the divided rate, so the controller stays in the bus clock domain and times each pulse as one tick period. Software picks the divisor so that the period lands near 5 to 6.7 microseconds (150 to 200 kHz).

Only the first write after reset counts. It stores the divisor and prescale select, and it sets a loaded flag whatever data it carries. From then on the fields are frozen until the next reset. The loaded flag drives an enable output for erase and program and also releases the divider counters, so no ticks appear and no erase or program is permitted until the block has been configured.

Reading is combinational: while the read strobe is high the port returns the flag in bit 7, the prescale select in bit 6 and the divisor in bits 5:0. Reset is synchronous and active high.

Top module: `nvm_tick_divider`

## Requirements
- R1: While reset is high and in the first cycle after it, cfgLoaded, progEnable and tick are 0 and a read returns 8'h00.
- R2: With rdEn high, rdData is {loaded flag in bit 7, prescale select in bit 6, divisor in bits 5:0} in the same cycle; with rdEn low, rdData is 8'h00.
- R3: The first write after reset stores wrData[6] as the prescale select and wrData[5:0] as the divisor on the clock edge where wrEn is sampled high; wrData[7] has no effect.
- R4: The first write after reset sets the loaded flag on that edge, whatever data it carries, including 8'h00.
- R5: Once the flag is set, further writes change neither the flag nor the stored fields until reset.
- R6: progEnable is 0 while the flag is 0 and 1 in every cycle after the flag is set.
- R7: tick stays 0 in every cycle while the flag is 0.
- R8: With the prescale select at 0 and divisor D, tick is high in cycles D, 2D+1, 3D+2, ... counting the first cycle with the flag set as cycle 0, i.e. a period of D+1 bus cycles; D=0 gives a tick on every cycle.
- R9: With the prescale select at 1 and divisor D, the first tick is in cycle 8(D+1)-1 after the flag is set and the period is 8(D+1) bus cycles.
- R10: For any period above one cycle, tick is high for exactly one bus cycle per period.
- R11: A read in the same cycle as the first write returns the pre-write value 8'h00; the new value appears from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| wrEn | input | 1 | Write strobe for the configuration byte |
| wrData | input | 8 | Write data; bit 6 prescale select, bits 5:0 divisor |
| rdEn | input | 1 | Read strobe |
| rdData | output | 8 | Read data, combinational, zero when rdEn is low |
| cfgLoaded | output | 1 | Loaded flag, set by the first write after reset |
| progEnable | output | 1 | Permits erase and program operations |
| tick | output | 1 | One-cycle enable at the divided rate |

## Verification
The read path and the write-once load can land in the same cycle: a read issued together with the first write must still show the pre-write byte, and a read on the next cycle must show the flag and new fields. The bench provokes this right after reset with rdEn and wrEn asserted together, then judges the two reads against values built from the written byte. A second collision, an ignored write landing while the divider is counting, is provoked in every random trial, and is judged by reading the fields back unchanged and measuring that the following tick interval still equals the period computed from the first write.

// File: rtl/nvm_tick_pkg.sv
package nvm_tick_pkg;
  localparam int CFG_W     = 8;
  localparam int DIV_W     = 6;
  localparam int PRE_RATIO = 8;

  typedef struct packed {
    logic cfgLoad;   // capture the configuration fields this edge
    logic countRun;  // release the prescaler and divider counters
  } ctrlStrobe_t;
endpackage

// File: rtl/nvm_tick_ctrl.sv
module nvm_tick_ctrl
  import nvm_tick_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wrEn,
  output ctrlStrobe_t strobe,
  output logic        loaded
);
  logic loadedQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      loadedQ <= 1'b0;
    end else if (wrEn) begin
      loadedQ <= 1'b1;
    end
  end

  always_comb begin
    strobe.cfgLoad  = wrEn & ~loadedQ;
    strobe.countRun = loadedQ;
  end

  assign loaded = loadedQ;
endmodule

// File: rtl/nvm_tick_dp.sv
module nvm_tick_dp
  import nvm_tick_pkg::*;
#(
  parameter int DivW     = DIV_W,
  parameter int PreRatio = PRE_RATIO,
  localparam int CfgW    = DivW + 2
) (
  input  logic             clk,
  input  logic             rst,
  input  ctrlStrobe_t      strobe,
  input  logic [CfgW-2:0]  wrFields,
  input  logic             loaded,
  input  logic             rdEn,
  output logic [CfgW-1:0]  rdData,
  output logic             cfgPre,
  output logic [DivW-1:0]  cfgDiv,
  output logic             tick
);
  logic            preTick;
  logic [DivW-1:0] divCnt;

  // configuration fields, captured once
  always_ff @(posedge clk) begin
    if (rst) begin
      cfgPre <= 1'b0;
      cfgDiv <= '0;
    end else if (strobe.cfgLoad) begin
      cfgPre <= wrFields[DivW];
      cfgDiv <= wrFields[DivW-1:0];
    end
  end

  // optional fixed prescaler stage
  generate
    if (PreRatio > 1) begin : g_pre
      localparam int PreW = $clog2(PreRatio);
      localparam logic [PreW-1:0] PreLast = PreW'(PreRatio - 1);
      logic [PreW-1:0] preCnt;

      always_ff @(posedge clk) begin
        if (rst || !strobe.countRun || !cfgPre) begin
          preCnt <= '0;
        end else if (preCnt == PreLast) begin
          preCnt <= '0;
        end else begin
          preCnt <= preCnt + 1'b1;
        end
      end

      assign preTick = !cfgPre || (preCnt == PreLast);
    end else begin : g_nopre
      assign preTick = 1'b1;
    end
  endgenerate

  // divide by (divisor + 1)
  always_ff @(posedge clk) begin
    if (rst || !strobe.countRun) begin
      divCnt <= '0;
    end else if (preTick) begin
      if (divCnt == cfgDiv) begin
        divCnt <= '0;
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

  assign tick = strobe.countRun && preTick && (divCnt == cfgDiv);

  assign rdData = rdEn ? {loaded, cfgPre, cfgDiv} : '0;
endmodule

// File: rtl/nvm_tick_divider.sv
module nvm_tick_divider
  import nvm_tick_pkg::*;
#(
  parameter int DivW     = DIV_W,
  parameter int PreRatio = PRE_RATIO,
  localparam int CfgW    = DivW + 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wrEn,
  input  logic [CfgW-1:0] wrData,
  input  logic            rdEn,
  output logic [CfgW-1:0] rdData,
  output logic            cfgLoaded,
  output logic            progEnable,
  output logic            tick
);
  ctrlStrobe_t     strobe;
  logic            loaded;
  logic            cfgPre;
  logic [DivW-1:0] cfgDiv;
  logic            unusedFlagBit;

  assign unusedFlagBit = wrData[CfgW-1];

  nvm_tick_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .wrEn   (wrEn),
    .strobe (strobe),
    .loaded (loaded)
  );

  nvm_tick_dp #(
    .DivW     (DivW),
    .PreRatio (PreRatio)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .wrFields (wrData[CfgW-2:0]),
    .loaded   (loaded),
    .rdEn     (rdEn),
    .rdData   (rdData),
    .cfgPre   (cfgPre),
    .cfgDiv   (cfgDiv),
    .tick     (tick)
  );

  assign cfgLoaded  = loaded;
  assign progEnable = loaded;
endmodule

// File: rtl/nvm_tick_checker.sv
module nvm_tick_checker #(
  parameter int DivW = 6
) (
  input logic            clk,
  input logic            rst,
  input logic            wrEn,
  input logic            cfgLoaded,
  input logic            progEnable,
  input logic            tick,
  input logic            cfgPre,
  input logic [DivW-1:0] cfgDiv
);
  // R4
  flag_needs_write_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cfgLoaded) |-> $past(wrEn));

  // R5
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    cfgLoaded |=> cfgLoaded);

  // R5
  fields_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    cfgLoaded |=> $stable({cfgPre, cfgDiv}));

  // R6
  enable_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    progEnable |=> progEnable);

  // R7
  no_early_tick_chk: assert property (@(posedge clk) disable iff (rst)
    !cfgLoaded |-> !tick);

  // R10
  single_tick_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && (cfgPre || cfgDiv != '0)) |=> !tick);
endmodule

bind nvm_tick_divider nvm_tick_checker #(.DivW(DivW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .wrEn       (wrEn),
  .cfgLoaded  (cfgLoaded),
  .progEnable (progEnable),
  .tick       (tick),
  .cfgPre     (cfgPre),
  .cfgDiv     (cfgDiv)
);

// File: tb/nvm_tick_divider_bench.sv
module nvm_tick_divider_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic       rdEn = 1'b0;
  logic [7:0] rdData;
  logic       cfgLoaded;
  logic       progEnable;
  logic       tick;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  nvm_tick_divider u_nvm_tick_divider (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn),
    .rdData(rdData), .cfgLoaded(cfgLoaded), .progEnable(progEnable), .tick(tick)
  );

  function automatic int expPeriod(logic [7:0] cfg);
    return cfg[6] ? 8 * (int'(cfg[5:0]) + 1) : int'(cfg[5:0]) + 1;
  endfunction

  function automatic logic [7:0] expRead(logic [7:0] cfg);
    return {1'b1, cfg[6:0]};
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // inputs change at posedge+1, outputs sampled at posedge+3
  task automatic doReset();
    rst = 1'b1; wrEn = 1'b0; rdEn = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
  endtask

  task automatic busWrite(logic [7:0] d);
    wrEn = 1'b1; wrData = d;
    @(posedge clk); #1 wrEn = 1'b0;
  endtask

  task automatic readBack(output logic [7:0] v);
    rdEn = 1'b1; #2 v = rdData;
    @(posedge clk); #1 rdEn = 1'b0;
  endtask

  // returns the number of non-tick cycles before the next tick
  task automatic waitTick(output int n);
    n = 0;
    forever begin
      #2;
      if (tick || n > 5000) break;
      @(posedge clk); #1 n++;
    end
    @(posedge clk); #1;
  endtask

  task automatic trial(logic [7:0] cfg, logic [7:0] other);
    logic [7:0] v;
    int n;
    int p;
    int quiet;
    p = expPeriod(cfg);
    doReset();
    // R1 reset state seen in the first cycle after reset
    rdEn = 1'b1; #2;
    check(rdData == 8'h00 && !cfgLoaded && !progEnable && !tick, "R1",
          {rdData, cfgLoaded, progEnable, tick}, 0);
    @(posedge clk); #1 rdEn = 1'b0;
    // R7 R6: idle unconfigured cycles
    quiet = 1;
    for (int i = 0; i < 12; i++) begin
      #2 if (tick || progEnable) quiet = 0;
      @(posedge clk); #1;
    end
    check(quiet == 1, "R7/R6 idle before load", quiet, 1);
    busWrite(cfg);
    waitTick(n);
    check(n == p - 1, cfg[6] ? "R9 first tick" : "R8 first tick", n, p - 1);
    waitTick(n);
    check(n == p - 1, cfg[6] ? "R9 period" : "R8 period", n, p - 1);
    // R5 ignored write while counting
    busWrite(other);
    readBack(v);
    check(v == expRead(cfg), "R5 R3 readback", v, expRead(cfg));
    check(progEnable && cfgLoaded, "R6 enable high", progEnable, 1);
    waitTick(n);
    waitTick(n);
    check(n == p - 1, "R5 R10 period unchanged", n, p - 1);
  endtask

  initial begin
    logic [7:0] v;
    void'($urandom(32'h5eed_1234));
    doReset();

    // R11 R4 read colliding with first write of 8'h00 data
    rdEn = 1'b1; wrEn = 1'b1; wrData = 8'h00; #2;
    check(rdData == 8'h00, "R11 pre-write read", rdData, 0);
    @(posedge clk); #1 wrEn = 1'b0; #2;
    check(rdData == 8'h80, "R4 flag on zero write", rdData, 8'h80);
    check(progEnable == 1'b1, "R6 enable after load", progEnable, 1);
    // R2 read gated by rdEn
    rdEn = 1'b0; #1;
    check(rdData == 8'h00, "R2 idle read zero", rdData, 0);
    @(posedge clk); #1;

    // R11 collision with non-zero data, bit 7 of data set (R3)
    doReset();
    rdEn = 1'b1; wrEn = 1'b1; wrData = 8'hD5; #2;
    check(rdData == 8'h00, "R11 pre-write read 2", rdData, 0);
    @(posedge clk); #1 wrEn = 1'b0; #2;
    check(rdData == 8'hD5, "R2 R3 field layout", rdData, 8'hD5);
    @(posedge clk); #1 rdEn = 1'b0;

    // directed corners
    trial(8'h00, 8'h7F);   // R8 D=0, tick every cycle
    trial(8'h01, 8'h40);
    trial(8'h3F, 8'h00);
    trial(8'h40, 8'h3F);   // R9 D=0
    trial(8'h7F, 8'h01);   // R9 longest
    trial(8'h80, 8'h55);   // R3 bit 7 ignored

    // constrained random
    for (int t = 0; t < 16; t++) begin
      logic [7:0] a;
      logic [7:0] b;
      a = 8'($urandom);
      if (t % 2 == 0) a[6] = 1'b0;
      if (a[6]) a[5:3] = 3'b000;
      b = 8'($urandom);
      if (b[6:0] == a[6:0]) b[0] = ~b[0];
      trial(a, b);
    end

    readBack(v);
    check(v[7] == 1'b1, "R5 final flag", v, 8'h80);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule